// File: doc/BRIEF.md
# Cascade Power Sequencer

This block brings up to three power channels up and down in a fixed order. Each channel has a small position code. On a start command the controller walks the positions from first to last. For each position it switches on the channels that carry that position code and are requested on. It moves on only when every one of those channels reports, through its power-good comparator flag, that its output has crossed threshold. After each completed position it waits a selectable number of timebase ticks. A position with nothing to switch on is passed over.

A stop command reverses the walk. It starts at the last position and switches that position's channels off. It waits until their power-good flags drop, waits the delay for that position, and then moves one position lower. Requests are not consulted while powering down. A force command, an input-supply fault or any output fault clears every drive enable at once. A watchdog that restarts at each position also clears every enable if the position takes too long, and it leaves a sticky flag. In manual mode each drive enable simply follows its request. The sequencer is then held idle and faults have no effect. All timing is counted on a 1 kHz tick-enable input, so each programmable delay is a whole number of ticks.

Top module: `casc_pwr_seq`

## Requirements
- R1: After reset all drive enables are 0, the position output is 0, busy is 0 and the watchdog flag is 0.
- R2: Position codes are 2 bits per channel (channel c at bits [2c+1:2c]). Codes 0..2 are positions and code 3 leaves the channel unsequenced. At the end of a power-up with the watchdog disabled, the drive enables equal the requests of the channels whose code is 0..2.
- R3: A position completes only when every channel in it that was requested and switched on shows power-good. Until then no later position's channel is switched on and the position output stays unchanged.
- R4: A position in which no channel is requested is left one cycle after it is reached. No delay is added for it, and its unrequested channels stay off.
- R5: The 2-bit delay select for position p (bits [2p+1:2p]) picks 0..3 → DLY_T0..DLY_T3 ticks (defaults 2, 13, 25, 50). With a tick every cycle, the channels of the next position are switched on DLY+2 rising edges after power-good completes the position, counting the first edge that samples the completion as edge 1.
- R6: The watchdog select 0 disables it, and 1..3 pick TRM_T1..TRM_T3 ticks (defaults 50, 100, 200). The watchdog restarts when each position begins. On expiry all enables clear, the sequencer goes idle and the flag sets. With a tick every cycle this happens on the TRM+1th edge counted from the edge that accepts the start.
- R7: The watchdog flag stays set until the next accepted start command, which clears it.
- R8: A stop command takes the sequencer to the last position. The last position's channels turn off on the second edge after the stop is sampled. A lower position's channels turn off only after every higher position's channels are off and their power-good flags are low. Requests are ignored while powering down. The sequencer ends idle at position 0.
- R9: A force command, an input-supply fault or any output fault clears all enables and returns the sequencer to idle at position 0 on the next edge.
- R10: In manual mode each drive enable equals its request in the same cycle, with no effect from faults or commands. Leaving manual mode leaves all enables off and the sequencer idle.
- R11: Busy is high while powering up or down, including delays. It is low when idle and when fully on. When fully on, the position output shows the last position (2).
- R12: Delay and watchdog counters advance only in cycles with the tick input high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick enable (1 kHz) |
| pos_code_i | input | N_CH*PW | Position code per channel |
| req_en_i | input | N_CH | Per-channel enable request |
| pgood_i | input | N_CH | Per-channel output-above-threshold flag |
| start_i | input | 1 | Begin power-up |
| stop_i | input | 1 | Begin power-down |
| force_i | input | 1 | Force immediate shutdown |
| vin_fault_i | input | 1 | Input-supply fault |
| out_fault_i | input | N_CH | Per-channel output UV/OV fault |
| manual_i | input | 1 | Manual mode: enables follow requests |
| dly_sel_i | input | 2*N_POS | Inter-position delay select per position |
| term_sel_i | input | 2 | Watchdog period select, 0 disables |
| drv_en_o | output | N_CH | Per-channel drive enable |
| pos_o | output | PW | Current position |
| busy_o | output | 1 | Sequencing in progress |
| trip_o | output | 1 | Sticky watchdog shutdown flag |

## Verification
The bench builds the block with delays of 2, 3, 5 and 7 ticks and watchdog periods of 20, 40 and 60 ticks. This keeps every watchdog expiry within a few dozen cycles, so exact edge counts for delays, skips and expiry can be checked against DLY+2, DLY+3 and TRM+1. Because the four delay values are all different, a wrong select index or a wrong code mapping shows up as a wrong count. A plant model in the bench returns power-good a random few cycles after each enable. This lets random position codes, requests and lags exercise ordering in both directions, together with unsequenced channels and all-skip cases.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_UP_POS, S_UP_DLY, S_ON, S_DN_POS, S_DN_DLY
  } seq_st_e;

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pseq_posmap.sv
module pseq_posmap #(
  parameter int N_CH = 3,
  parameter int PW   = 2
) (
  input  logic [N_CH*PW-1:0] code_i,
  input  logic [PW-1:0]      sel_i,
  output logic [N_CH-1:0]    hit_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assign hit_o[c] = (code_i[c*PW +: PW] == sel_i);
  end
endmodule

// File: rtl/pseq_timer.sv
module pseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] lim_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (run_i && tick_i) cnt_q <= cnt_q + 1'b1;
  end

  // limit is at least 1
  assign done_o = run_i && tick_i && (cnt_q >= lim_i - 1'b1);

  a_r12_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !tick_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pseq_fsm.sv
module pseq_fsm
  import pseq_pkg::*;
#(
  parameter int N_CH  = 3,
  parameter int N_POS = 3,
  parameter int PW    = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic            kill_i,
  input  logic            manual_i,
  input  logic [N_CH-1:0] req_en_i,
  input  logic [N_CH-1:0] pgood_i,
  input  logic [N_CH-1:0] mem_i,
  input  logic            dly_done_i,
  input  logic            trm_done_i,
  output seq_st_e         st_o,
  output logic [PW-1:0]   pos_o,
  output logic [N_CH-1:0] mask_o,
  output logic            trip_o,
  output logic            adv_o
);
  localparam logic [PW-1:0] LAST = PW'(N_POS - 1);

  seq_st_e         st_q, st_n;
  logic [PW-1:0]   pos_q, pos_n;
  logic [N_CH-1:0] mask_q, mask_n, act;
  logic            trip_q, trip_n, adv;

  assign act = mem_i & req_en_i;

  always_comb begin
    st_n   = st_q;
    pos_n  = pos_q;
    mask_n = mask_q;
    trip_n = trip_q;
    adv    = 1'b0;
    if (manual_i || kill_i) begin
      st_n = S_IDLE; pos_n = '0; mask_n = '0;
    end else if (trm_done_i) begin
      st_n = S_IDLE; pos_n = '0; mask_n = '0; trip_n = 1'b1;
    end else if (stop_i && (st_q == S_UP_POS || st_q == S_UP_DLY || st_q == S_ON)) begin
      st_n = S_DN_POS; pos_n = LAST; adv = 1'b1;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          st_n = S_UP_POS; pos_n = '0; trip_n = 1'b0; adv = 1'b1;
        end
        S_UP_POS: begin
          mask_n = mask_q | act;
          if (act == '0) begin
            adv = 1'b1;
            if (pos_q == LAST) st_n = S_ON;
            else               pos_n = pos_q + 1'b1;
          end else if ((act & ~pgood_i) == '0 && (act & ~mask_q) == '0) begin
            adv  = 1'b1;
            st_n = (pos_q == LAST) ? S_ON : S_UP_DLY;
          end
        end
        S_UP_DLY: if (dly_done_i) begin
          st_n = S_UP_POS; pos_n = pos_q + 1'b1; adv = 1'b1;
        end
        S_DN_POS: begin
          mask_n = mask_q & ~mem_i;
          if (((mask_q | pgood_i) & mem_i) == '0) begin
            adv  = 1'b1;
            st_n = (pos_q == '0) ? S_IDLE : S_DN_DLY;
          end
        end
        S_DN_DLY: if (dly_done_i) begin
          st_n = S_DN_POS; pos_n = pos_q - 1'b1; adv = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; pos_q <= '0; mask_q <= '0; trip_q <= 1'b0;
    end else begin
      st_q <= st_n; pos_q <= pos_n; mask_q <= mask_n; trip_q <= trip_n;
    end
  end

  assign st_o   = st_q;
  assign pos_o  = pos_q;
  assign mask_o = mask_q;
  assign trip_o = trip_q;
  assign adv_o  = adv;

  a_r3_advance_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_UP_POS && $past(st_q) == S_UP_POS && pos_q != $past(pos_q))
      |-> ($past(mem_i & req_en_i & ~pgood_i) == '0));

  a_r8_down_never_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q) == S_DN_POS || $past(st_q) == S_DN_DLY)
      |-> ((mask_q & ~$past(mask_q)) == '0));

  a_r9_kill_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill_i |=> (mask_q == '0 && st_q == S_IDLE));

  a_r7_trip_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trip_q && !start_i) |=> trip_q);

  a_r6_trip_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(trip_q) |-> $past(trm_done_i));
endmodule

// File: rtl/casc_pwr_seq.sv
module casc_pwr_seq
  import pseq_pkg::*;
#(
  parameter int unsigned N_CH   = 3,
  parameter int unsigned N_POS  = 3,
  parameter int unsigned DLY_T0 = 2,
  parameter int unsigned DLY_T1 = 13,
  parameter int unsigned DLY_T2 = 25,
  parameter int unsigned DLY_T3 = 50,
  parameter int unsigned TRM_T1 = 50,
  parameter int unsigned TRM_T2 = 100,
  parameter int unsigned TRM_T3 = 200,
  localparam int unsigned PW    = $clog2(N_POS + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [N_CH*PW-1:0]   pos_code_i,
  input  logic [N_CH-1:0]      req_en_i,
  input  logic [N_CH-1:0]      pgood_i,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 force_i,
  input  logic                 vin_fault_i,
  input  logic [N_CH-1:0]      out_fault_i,
  input  logic                 manual_i,
  input  logic [2*N_POS-1:0]   dly_sel_i,
  input  logic [1:0]           term_sel_i,
  output logic [N_CH-1:0]      drv_en_o,
  output logic [PW-1:0]        pos_o,
  output logic                 busy_o,
  output logic                 trip_o
);
  localparam int unsigned MAXT = umax(umax(umax(DLY_T0, DLY_T1), umax(DLY_T2, DLY_T3)),
                                      umax(umax(TRM_T1, TRM_T2), TRM_T3));
  localparam int unsigned CW   = $clog2(MAXT + 1);

  seq_st_e         st;
  logic [PW-1:0]   pos;
  logic [N_CH-1:0] mem, mask;
  logic            kill, adv, in_pos, in_dly;
  logic            dly_done, trm_done, trm_en;
  logic [1:0]      dsel;
  logic [CW-1:0]   dly_lim, trm_lim;

  assign kill   = force_i | vin_fault_i | (|out_fault_i);
  assign in_pos = (st == S_UP_POS) || (st == S_DN_POS);
  assign in_dly = (st == S_UP_DLY) || (st == S_DN_DLY);
  assign trm_en = (term_sel_i != 2'd0);

  pseq_posmap #(.N_CH(N_CH), .PW(PW)) u_map (
    .code_i (pos_code_i),
    .sel_i  (pos),
    .hit_o  (mem)
  );

  always_comb begin
    dsel = '0;
    for (int p = 0; p < N_POS; p++)
      if (pos == PW'(p)) dsel = dly_sel_i[p*2 +: 2];
  end

  always_comb begin
    case (dsel)
      2'd0:    dly_lim = CW'(DLY_T0);
      2'd1:    dly_lim = CW'(DLY_T1);
      2'd2:    dly_lim = CW'(DLY_T2);
      default: dly_lim = CW'(DLY_T3);
    endcase
    case (term_sel_i)
      2'd1:    trm_lim = CW'(TRM_T1);
      2'd2:    trm_lim = CW'(TRM_T2);
      default: trm_lim = CW'(TRM_T3);
    endcase
  end

  pseq_timer #(.CW(CW)) u_dly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_dly),
    .run_i  (in_dly),
    .tick_i (tick_i),
    .lim_i  (dly_lim),
    .done_o (dly_done)
  );

  pseq_timer #(.CW(CW)) u_trm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (!in_pos || adv),
    .run_i  (in_pos && trm_en),
    .tick_i (tick_i),
    .lim_i  (trm_lim),
    .done_o (trm_done)
  );

  pseq_fsm #(.N_CH(N_CH), .N_POS(N_POS), .PW(PW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .kill_i     (kill),
    .manual_i   (manual_i),
    .req_en_i   (req_en_i),
    .pgood_i    (pgood_i),
    .mem_i      (mem),
    .dly_done_i (dly_done),
    .trm_done_i (trm_done),
    .st_o       (st),
    .pos_o      (pos),
    .mask_o     (mask),
    .trip_o     (trip_o),
    .adv_o      (adv)
  );

  assign drv_en_o = manual_i ? req_en_i : mask;
  assign pos_o    = pos;
  assign busy_o   = in_pos || in_dly;

  a_r10_manual_ignores_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (manual_i && $past(manual_i) && $stable(req_en_i)) |-> $stable(drv_en_o));

  a_r11_idle_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(kill) && !$past(manual_i)) |-> !busy_o);
endmodule

// File: tb/casc_pwr_seq_tb_top.sv
module casc_pwr_seq_tb_top;
  localparam int NC = 3, NP = 3, PW = 2;
  localparam int TB_D0 = 2, TB_D1 = 3, TB_D2 = 5, TB_D3 = 7;
  localparam int TB_T1 = 20, TB_T2 = 40, TB_T3 = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          tick = 1'b1;
  logic [5:0]    pos_code = '0;
  logic [2:0]    req = '0, pg_man = '0, pg_auto = '0, pgood, out_fault = '0;
  logic          start = 0, stop = 0, frc = 0, vin_fault = 0, manual = 0, auto_pg = 0;
  logic [5:0]    dly_sel = '0;
  logic [1:0]    term_sel = '0;
  logic [2:0]    drv;
  logic [1:0]    pos;
  logic          busy, trip;

  assign pgood = auto_pg ? pg_auto : pg_man;

  casc_pwr_seq #(.N_CH(NC), .N_POS(NP), .DLY_T0(TB_D0), .DLY_T1(TB_D1), .DLY_T2(TB_D2),
    .DLY_T3(TB_D3), .TRM_T1(TB_T1), .TRM_T2(TB_T2), .TRM_T3(TB_T3)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pos_code_i(pos_code), .req_en_i(req),
    .pgood_i(pgood), .start_i(start), .stop_i(stop), .force_i(frc), .vin_fault_i(vin_fault),
    .out_fault_i(out_fault), .manual_i(manual), .dly_sel_i(dly_sel), .term_sel_i(term_sel),
    .drv_en_o(drv), .pos_o(pos), .busy_o(busy), .trip_o(trip));

  int n_chk = 0, n_bad = 0, inv_bad = 0;
  bit inv_on = 0;
  int lag [NC];
  logic [7:0] hist [NC];

  task automatic chk(bit ok, string req_id, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req_id, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  function automatic logic [2:0] exp_mask(logic [5:0] codes, logic [2:0] r);
    logic [2:0] m;
    for (int c = 0; c < NC; c++) m[c] = r[c] && (codes[c*2 +: 2] != 2'd3);
    return m;
  endfunction

  // plant: power-good follows drive with a per-channel lag; ordering monitor
  initial begin
    for (int c = 0; c < NC; c++) begin hist[c] = '0; lag[c] = 0; end
    forever begin
      @(negedge clk);
      for (int c = 0; c < NC; c++) begin
        hist[c] = {hist[c][6:0], drv[c]};
        pg_auto[c] = hist[c][lag[c]];
      end
      if (inv_on) begin
        for (int c = 0; c < NC; c++) begin
          for (int d = 0; d < NC; d++) begin
            if (pos_code[c*2 +: 2] != 2'd3 && pos_code[d*2 +: 2] != 2'd3 && req[d] &&
                pos_code[d*2 +: 2] < pos_code[c*2 +: 2]) begin
              if (drv[c] && !pg_auto[d]) inv_bad++;
              if (!drv[d] && drv[c]) inv_bad++;
            end
          end
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1; step(1); start = 0;
  endtask
  task automatic pulse_stop();
    stop = 1; step(1); stop = 0;
  endtask
  task automatic pulse_force();
    frc = 1; step(1); frc = 0;
  endtask

  task automatic wait_drv(int c, bit v, output int n);
    n = 0;
    while (drv[c] !== v && n < 2000) begin @(posedge clk); n++; @(negedge clk); end
  endtask

  task automatic wait_idle();
    int n = 0;
    step(1);
    while (busy && n < 5000) begin step(1); n++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    step(3); rst_n = 1; step(1);
    chk(drv == 3'b000, "R1 drv", drv, 0);
    chk(pos == 2'd0, "R1 pos", pos, 0);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(trip == 1'b0, "R1 trip", trip, 0);

    // R3 / R5: gating and exact delay
    pos_code = {2'd1, 2'd1, 2'd0}; req = 3'b111; dly_sel = 6'b000010;
    pulse_start();
    wait_drv(0, 1, n);
    step(8);
    chk(drv == 3'b001, "R3 no advance", drv, 1);
    chk(pos == 2'd0 && busy, "R3 held pos", pos, 0);
    pg_man = 3'b001;
    wait_drv(1, 1, n);
    chk(n == TB_D2 + 2, "R5 delay edges", n, TB_D2 + 2);
    pg_man = 3'b011; step(8);
    chk(pos == 2'd1 && busy, "R3 partial pgood", pos, 1);
    pg_man = 3'b111; wait_idle();
    chk(drv == 3'b111 && pos == 2'd2, "R11 fully on", {pos, drv}, {2'd2, 3'b111});
    pulse_force();
    chk(drv == 3'b000 && !busy && pos == 2'd0, "R9 force", drv, 0);
    pg_man = '0;

    // R4: skip of an unrequested position
    pos_code = {2'd1, 2'd2, 2'd0}; req = 3'b011; dly_sel = 6'b000001;
    pulse_start();
    wait_drv(0, 1, n);
    pg_man = 3'b001;
    wait_drv(1, 1, n);
    chk(n == TB_D1 + 3, "R4 skip edges", n, TB_D1 + 3);
    chk(drv[2] == 1'b0, "R4 skipped channel off", drv, 3);
    pg_man = 3'b011; step(1);
    chk(!busy && pos == 2'd2, "R11 not busy when on", busy, 0);
    vin_fault = 1; step(1); vin_fault = 0;
    chk(drv == 3'b000 && !busy, "R9 vin fault", drv, 0);
    pg_man = '0;

    // R6 / R7: watchdog
    pos_code = {2'd3, 2'd3, 2'd0}; req = 3'b001; term_sel = 2'd1;
    start = 1; n = 0;
    do begin @(posedge clk); n++; @(negedge clk); start = 0; end while (!trip && n < 2000);
    chk(n == TB_T1 + 1, "R6 expiry edges", n, TB_T1 + 1);
    chk(drv == 3'b000 && !busy, "R6 shutdown", drv, 0);
    step(30); pulse_stop();
    chk(trip == 1'b1, "R7 sticky", trip, 1);
    term_sel = 2'd0; pulse_start();
    chk(trip == 1'b0, "R7 cleared by start", trip, 0);
    pulse_force();

    // R12: no ticks, no expiry
    term_sel = 2'd1; tick = 0; pulse_start();
    step(3 * TB_T1);
    chk(!trip && busy, "R12 no tick no count", trip, 0);
    tick = 1; step(TB_T1 + 2);
    chk(trip == 1'b1, "R12 counts with tick", trip, 1);
    term_sel = 2'd0; pulse_force();

    // R8: power-down order with requests dropped
    auto_pg = 1; lag[0] = 2; lag[1] = 3; lag[2] = 1;
    pos_code = {2'd2, 2'd1, 2'd0}; req = 3'b111; dly_sel = 6'b111001;
    pulse_start(); wait_idle();
    chk(drv == 3'b111, "R2 directed up", drv, 7);
    req = 3'b000; pulse_stop();
    wait_drv(2, 0, n);
    chk(n == 1, "R8 last off edges", n, 1);
    chk(drv[1:0] == 2'b11, "R8 last first", drv, 3);
    wait_drv(1, 0, n);
    chk(drv[0] == 1'b1 && pgood[2] == 1'b0, "R8 middle after last low", {pgood, drv}, 1);
    wait_drv(0, 0, n); wait_idle();
    chk(drv == 3'b000 && pos == 2'd0 && !busy, "R8 end idle", drv, 0);
    step(10);

    // R10: manual mode
    manual = 1;
    for (int i = 0; i < 40; i++) begin
      req = 3'($urandom); out_fault = 3'($urandom); vin_fault = 1'($urandom);
      frc = 1'($urandom); start = 1'($urandom); stop = 1'($urandom);
      step(1);
      chk(drv == req, "R10 follow", drv, req);
    end
    out_fault = '0; vin_fault = 0; frc = 0; start = 0; stop = 0;
    manual = 0; step(1);
    chk(drv == 3'b000 && !busy, "R10 exit", drv, 0);
    step(10);

    // R2 / R8 / R9: random rounds
    for (int it = 0; it < 24; it++) begin
      for (int c = 0; c < NC; c++) lag[c] = $urandom_range(0, 5);
      pos_code = 6'($urandom); req = 3'($urandom); dly_sel = 6'($urandom);
      step(2); inv_on = 1;
      pulse_start(); wait_idle();
      chk(drv == exp_mask(pos_code, req), "R2 random up", drv, exp_mask(pos_code, req));
      if (it % 2 == 0) begin
        pulse_stop(); wait_idle();
        chk(drv == 3'b000 && pos == 2'd0, "R8 random down", drv, 0);
        inv_on = 0;
      end else begin
        inv_on = 0;
        out_fault = 3'(1 << $urandom_range(0, 2)); step(1); out_fault = '0;
        chk(drv == 3'b000 && !busy, "R9 output fault", drv, 0);
      end
      step(10);
    end
    chk(inv_bad == 0, "R3 ordering monitor", inv_bad, 0);
    finish_run();
  end
endmodule